// File: doc/BRIEF.md
# Toroidal Life Generation Stepper

This block computes the next generation of a Life cellular automaton. The grid is a torus of single-bit cells. The current generation is held in three memory banks that can all be read in the same cycle. Grid row `r` is stored in bank `r mod 3`, at slot `r / 3`. The column is the address inside that slot. Each result bit is written into the other half of a two-half buffer.

An external sequencer issues one row command per grid row. For each command the block first fills a 3x3 window of registers: the row above, the row itself and the row below, at columns `-1`, `0` and `1`. It then slides the window one column per clock. On each step it fetches only the three cells of the new leading column. After that it produces one new cell per clock.

A one-cycle pulse marks the end of each row. Once every row of the grid is done, a vertical-blank strobe exchanges the roles of the two buffer halves.

The row being computed is tracked by a counter that also keeps a one-hot modulo-3 bank selector and a slot index. No division is needed.

Top module: `life_stepper`

## Requirements
- R1: Each written cell follows the Life rule over its eight neighbours. A dead cell with exactly 3 live neighbours becomes live. A live cell with 2 or 3 live neighbours stays live. Every other cell becomes dead.
- R2: Neighbourhoods wrap at every edge, so row 0 borders row ROWS-1 and column 0 borders column COLS-1.
- R3: ROWS is a multiple of 3. Grid row r is fetched from bank r mod 3. `rd_slot[b]` selects the row slot in bank b, where slot s holds row 3*s+b, and `rd_col` is the column. `rd_data[b]` returns that bit one clock after `rd_en`.
- R4: Suppose `row_go` is sampled high at a clock edge while the block is idle. Then `wr_en` is high for exactly COLS consecutive cycles, starting with the fifth following edge, and `wr_col` runs 0, 1, ..., COLS-1.
- R5: Rows are computed in the order 0, 1, ..., ROWS-1 after reset and after each swap. `wr_row` gives the row being written, and `wr_half` is always the opposite of `cur_half`.
- R6: `row_go` is ignored while a row is in progress. It is also ignored after the last row of a generation until the next swap.
- R7: `row_done` is high for exactly one cycle, the cycle right after the last write of a row.
- R8: `vblank_swap` toggles `cur_half` only once all ROWS rows of the generation are done. At any other time it has no effect.
- R9: After reset, `cur_half` is 0 and `wr_en`, `rd_en` and `row_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_go | input | 1 | Start the next row (window fill, then sweep) |
| vblank_swap | input | 1 | Vertical-blank strobe that requests the buffer exchange |
| rd_en | output | 1 | Read strobe for all three banks |
| rd_col | output | $clog2(COLS) | Column address shared by the banks |
| rd_slot | output | 3 x SW | Row slot per bank, where SW = max(1, $clog2(ROWS/3)) |
| rd_data | input | 3 | One bit per bank, valid one clock after `rd_en` |
| wr_en | output | 1 | Next-state write strobe |
| wr_half | output | 1 | Buffer half that receives the write |
| wr_row | output | $clog2(ROWS) | Row of the written cell |
| wr_col | output | $clog2(COLS) | Column of the written cell |
| wr_cell | output | 1 | Next state of the cell |
| row_done | output | 1 | One-cycle end-of-row pulse |
| cur_half | output | 1 | Buffer half holding the current generation |

## Verification
The bench targets patterns that straddle the torus seams: a block split across all four corners, and a blinker crossing the top/bottom edge. A design with a wrong wrap index or a wrong bank rotation at row 0 or row ROWS-1 would break these apart or grow them. The window fill is checked cycle by cycle, so a sweep that starts a column early or late shows up as shifted or missing writes. Stray `row_go` pulses in the middle of a row and after the last row, and an early `vblank_swap`, probe the ignore rules. A design that restarted or swapped too soon would skip rows or write into the live half.

// File: rtl/life_pkg.sv
package life_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GEN  = 2'd2
    } step_state_e;

    // w[4] is the centre cell; the other eight bits are its neighbours
    function automatic logic life_rule(input logic [8:0] w);
        logic [3:0] cnt;
        cnt = 4'd0;
        for (int i = 0; i < 9; i++) begin
            if (i != 4) cnt = cnt + {3'd0, w[i]};
        end
        return (cnt == 4'd3) || (w[4] && cnt == 4'd2);
    endfunction

endpackage

// File: rtl/life_row_ctr.sv
module life_row_ctr #(
    parameter int ROWS = 6,
    localparam int SLOTS = ROWS / 3,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          clr,
    output logic [RW-1:0] row,
    output logic [2:0]    mid_sel,
    output logic [SW-1:0] up_slot,
    output logic [SW-1:0] mid_slot,
    output logic [SW-1:0] dn_slot,
    output logic          last_row
);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [2:0]    sel;
        logic [SW-1:0] slot;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    initial begin
        assert_rows_div3_R3: assert (ROWS % 3 == 0 && ROWS >= 3)
            else $error("ROWS must be a positive multiple of 3");
    end

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d.row  = '0;
            ctr_d.sel  = 3'b001;
            ctr_d.slot = '0;
        end else if (adv) begin
            if (ctr_q.row == RW'(ROWS - 1)) begin
                ctr_d.row  = '0;
                ctr_d.sel  = 3'b001;
                ctr_d.slot = '0;
            end else begin
                ctr_d.row = ctr_q.row + RW'(1);
                ctr_d.sel = {ctr_q.sel[1:0], ctr_q.sel[2]};
                if (ctr_q.sel[2]) ctr_d.slot = ctr_q.slot + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q.row  <= '0;
            ctr_q.sel  <= 3'b001;
            ctr_q.slot <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign row      = ctr_q.row;
    assign mid_sel  = ctr_q.sel;
    assign mid_slot = ctr_q.slot;
    assign last_row = (ctr_q.row == RW'(ROWS - 1));

    // row above: wraps from row 0 to row ROWS-1 (bank 2, last slot)
    always_comb begin
        if (!ctr_q.sel[0])           up_slot = ctr_q.slot;
        else if (ctr_q.row == '0)    up_slot = SW'(SLOTS - 1);
        else                         up_slot = ctr_q.slot - SW'(1);
    end

    // row below: wraps from row ROWS-1 to row 0 (bank 0, slot 0)
    always_comb begin
        if (!ctr_q.sel[2])           dn_slot = ctr_q.slot;
        else if (last_row)           dn_slot = '0;
        else                         dn_slot = ctr_q.slot + SW'(1);
    end

    assert_bank_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctr_q.sel) == 1);

    assert_bank_tracks_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !clr && ctr_q.row != RW'(ROWS - 1)
        |=> ctr_q.sel == {$past(ctr_q.sel[1:0]), $past(ctr_q.sel[2])});

endmodule

// File: rtl/life_window.sv
module life_window (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift,
    input  logic [2:0] col_in,   // [0]=row above, [1]=row, [2]=row below
    output logic       cell_next
);
    import life_pkg::*;

    // win[c][p]: c = 0 left, 1 centre, 2 right column; p as col_in
    logic [2:0][2:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (shift) begin
            win_d[0] = win_q[1];
            win_d[1] = win_q[2];
            win_d[2] = col_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign cell_next = life_rule({win_q[2], win_q[1], win_q[0]});

    assert_window_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(win_q));

endmodule

// File: rtl/life_stepper.sv
module life_stepper #(
    parameter int COLS = 8,
    parameter int ROWS = 6,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SLOTS = ROWS / 3,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int TW = $clog2(COLS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               row_go,
    input  logic               vblank_swap,
    output logic               rd_en,
    output logic [CW-1:0]      rd_col,
    output logic [2:0][SW-1:0] rd_slot,
    input  logic [2:0]         rd_data,
    output logic               wr_en,
    output logic               wr_half,
    output logic [RW-1:0]      wr_row,
    output logic [CW-1:0]      wr_col,
    output logic               wr_cell,
    output logic               row_done,
    output logic               cur_half
);
    import life_pkg::*;

    localparam logic [TW-1:0] LAST_TAG = TW'(COLS + 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    typedef struct packed {
        step_state_e   st;
        logic          iss;
        logic [TW-1:0] tag;
        logic          p1_vld;
        logic [TW-1:0] p1_tag;
        logic          win_vld;
        logic [TW-1:0] win_tag;
        logic          wr_en;
        logic [CW-1:0] wr_col;
        logic          wr_cell;
        logic          row_done;
        logic          half;
    } step_t;

    step_t s_d, s_q;

    logic          adv, clr, last_row, cell_next;
    logic [RW-1:0] row;
    logic [2:0]    mid_sel, up_sel, dn_sel;
    logic [SW-1:0] up_slot, mid_slot, dn_slot;
    logic [2:0]    col_in;
    logic [TW-1:0] tag_m1;

    life_row_ctr #(.ROWS(ROWS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .clr      (clr),
        .row      (row),
        .mid_sel  (mid_sel),
        .up_slot  (up_slot),
        .mid_slot (mid_slot),
        .dn_slot  (dn_slot),
        .last_row (last_row)
    );

    assign up_sel = {mid_sel[0], mid_sel[2:1]};
    assign dn_sel = {mid_sel[1:0], mid_sel[2]};

    generate
        for (genvar b = 0; b < 3; b++) begin : g_bank
            assign rd_slot[b] = up_sel[b]  ? up_slot  :
                                mid_sel[b] ? mid_slot : dn_slot;
        end
    endgenerate

    assign col_in = {|(rd_data & dn_sel), |(rd_data & mid_sel), |(rd_data & up_sel)};

    life_window u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (s_q.p1_vld),
        .col_in    (col_in),
        .cell_next (cell_next)
    );

    // fetch order per row: column COLS-1, then 0 .. COLS-1, then 0 again
    assign tag_m1 = s_q.tag - TW'(1);
    always_comb begin
        if (s_q.tag == '0)               rd_col = LAST_COL;
        else if (tag_m1 >= TW'(COLS))    rd_col = CW'(tag_m1 - TW'(COLS));
        else                             rd_col = CW'(tag_m1);
    end

    always_comb begin
        s_d = s_q;
        adv = 1'b0;
        clr = 1'b0;
        s_d.p1_vld  = s_q.iss;
        s_d.p1_tag  = s_q.tag;
        s_d.win_vld = s_q.p1_vld;
        if (s_q.p1_vld) s_d.win_tag = s_q.p1_tag;
        s_d.wr_en    = 1'b0;
        s_d.row_done = 1'b0;
        if (s_q.win_vld && s_q.win_tag >= TW'(2)) begin
            s_d.wr_en   = 1'b1;
            s_d.wr_col  = CW'(s_q.win_tag - TW'(2));
            s_d.wr_cell = cell_next;
        end
        case (s_q.st)
            ST_IDLE: begin
                if (row_go) begin
                    s_d.st  = ST_RUN;
                    s_d.iss = 1'b1;
                    s_d.tag = '0;
                end
            end
            ST_RUN: begin
                if (s_q.iss) begin
                    s_d.tag = s_q.tag + TW'(1);
                    if (s_q.tag == LAST_TAG) s_d.iss = 1'b0;
                end
                if (s_q.wr_en && s_q.wr_col == LAST_COL) begin
                    s_d.row_done = 1'b1;
                    adv          = 1'b1;
                    s_d.st       = last_row ? ST_GEN : ST_IDLE;
                end
            end
            ST_GEN: begin
                if (vblank_swap) begin
                    s_d.half = ~s_q.half;
                    clr      = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en    = s_q.iss;
    assign wr_en    = s_q.wr_en;
    assign wr_col   = s_q.wr_col;
    assign wr_cell  = s_q.wr_cell;
    assign wr_row   = row;
    assign wr_half  = ~s_q.half;
    assign row_done = s_q.row_done;
    assign cur_half = s_q.half;

    assert_row_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);

    assert_row_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> $past(wr_en) && $past(wr_col) == LAST_COL);

    assert_cols_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_col != '0 |-> $past(wr_en) && $past(wr_col) == wr_col - CW'(1));

    assert_col_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_col) < COLS);

    assert_swap_on_vblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_half != $past(cur_half) |-> $past(vblank_swap) && !$past(rd_en) && !$past(wr_en));

endmodule

// File: tb/sim_life_stepper.sv
module sim_life_stepper;
    localparam int COLS = 8;
    localparam int ROWS = 6;
    localparam int N    = COLS * ROWS;
    localparam int CW   = $clog2(COLS);
    localparam int RW   = $clog2(ROWS);
    localparam int SW   = 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               row_go = 1'b0;
    logic               vblank_swap = 1'b0;
    logic               rd_en;
    logic [CW-1:0]      rd_col;
    logic [2:0][SW-1:0] rd_slot;
    logic [2:0]         rd_data = '0;
    logic               wr_en, wr_half, wr_cell, row_done, cur_half;
    logic [RW-1:0]      wr_row;
    logic [CW-1:0]      wr_col;

    logic [N-1:0] mem [2];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    life_stepper #(.COLS(COLS), .ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .row_go(row_go), .vblank_swap(vblank_swap),
        .rd_en(rd_en), .rd_col(rd_col), .rd_slot(rd_slot), .rd_data(rd_data),
        .wr_en(wr_en), .wr_half(wr_half), .wr_row(wr_row), .wr_col(wr_col),
        .wr_cell(wr_cell), .row_done(row_done), .cur_half(cur_half)
    );

    // bank model (R3): bank b, slot s holds grid row 3*s+b
    always @(posedge clk) begin
        if (rd_en) begin
            for (int b = 0; b < 3; b++)
                rd_data[b] <= mem[cur_half][(3 * int'(rd_slot[b]) + b) * COLS + int'(rd_col)];
        end
    end

    typedef struct packed {
        logic [N-1:0] pat;
        logic [N-1:0] exp;
        logic [1:0]   req;   // 1: R1, 2: R2
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{pat: 48'h0,              exp: 48'h0,              req: 2'd1},
        '{pat: 48'h00000_01C0000,  exp: 48'h0000_0808_0800, req: 2'd1},
        '{pat: 48'hFFFF_FFFF_FFFF, exp: 48'h0,              req: 2'd1},
        '{pat: 48'h8100_0000_0081, exp: 48'h8100_0000_0081, req: 2'd2},
        '{pat: 48'h0100_0000_0101, exp: 48'h0000_0000_0083, req: 2'd2}
    };

    function automatic logic [N-1:0] life_ref(input logic [N-1:0] g);
        logic [N-1:0] o;
        o = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int cnt;
                cnt = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (dr != 0 || dc != 0)
                            cnt += int'(g[((r + dr + ROWS) % ROWS) * COLS + (c + dc + COLS) % COLS]);
                o[r * COLS + c] = (cnt == 3) || (g[r * COLS + c] && cnt == 2);
            end
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_row(input int r, input bit poke);
        bit t_ok = 1, o_ok = 1, d_ok = 1;
        int bad_k = -1;
        @(negedge clk) row_go = 1'b1;
        @(negedge clk) row_go = 1'b0;
        for (int k = 0; k <= COLS + 5; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == 2) row_go = 1'b1;
            if (poke && k == 3) row_go = 1'b0;
            if (wr_en != (k >= 5 && k <= COLS + 4)) begin t_ok = 0; bad_k = k; end
            if (wr_en) begin
                if (int'(wr_col) != k - 5) begin t_ok = 0; bad_k = k; end
                if (int'(wr_row) != r || wr_half != ~cur_half) o_ok = 0;
                mem[wr_half][int'(wr_row) * COLS + int'(wr_col)] = wr_cell;
            end
            if (row_done != (k == COLS + 5)) d_ok = 0;
        end
        check(t_ok, "R4 write timing", 64'(bad_k), 64'hFFFF_FFFF_FFFF_FFFF);
        check(o_ok, poke ? "R6 row after stray row_go" : "R5 row order/half",
              64'(wr_row), 64'(r));
        check(d_ok, "R7 row_done pulse", 64'(row_done), 64'(0));
    endtask

    task automatic run_gen(input logic [N-1:0] pat, input logic [N-1:0] exp,
                           input string req, input bit extras);
        logic h;
        h = cur_half;
        mem[h]  = pat;
        mem[~h] = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (extras && r == 2) begin
                // R8: early swap strobe must be ignored
                @(negedge clk) vblank_swap = 1'b1;
                @(negedge clk) vblank_swap = 1'b0;
                @(negedge clk);
                check(cur_half == h, "R8 early swap ignored", 64'(cur_half), 64'(h));
            end
            run_row(r, extras && r == 1);
        end
        check(mem[~h] == exp, req, 64'(mem[~h]), 64'(exp));
        if (extras) begin
            bit quiet = 1;
            // R6: row_go after the last row is ignored until swap
            @(negedge clk) row_go = 1'b1;
            @(negedge clk) row_go = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (wr_en || rd_en) quiet = 0;
            end
            check(quiet, "R6 row_go ignored after last row", 64'(quiet), 64'(1));
        end
        @(negedge clk) vblank_swap = 1'b1;
        @(negedge clk) vblank_swap = 1'b0;
        @(negedge clk);
        check(cur_half == ~h, "R8 swap after generation", 64'(cur_half), 64'(~h));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        mem[0] = '0;
        mem[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(cur_half == 1'b0, "R9 cur_half", 64'(cur_half), 64'(0));
        check(!wr_en && !rd_en && !row_done, "R9 strobes idle",
              64'({wr_en, rd_en, row_done}), 64'(0));

        for (int i = 0; i < 5; i++)
            run_gen(VECS[i].pat, VECS[i].exp, VECS[i].req == 2'd2 ? "R2 wrap" : "R1 rule", 0);

        // R3: random grids exercise every bank/slot mapping
        for (int i = 0; i < 4; i++) begin
            logic [N-1:0] p;
            p = N'({$urandom(i + 7), $urandom()});
            run_gen(p, life_ref(p), "R3 random grid", i == 1);
        end

        // R2: glider chain across edges over several generations
        begin
            logic [N-1:0] g;
            g = 48'h0000_0000_0000;
            g[0 * COLS + 7] = 1'b1;
            g[1 * COLS + 0] = 1'b1;
            g[2 * COLS + 6] = 1'b1;
            g[2 * COLS + 7] = 1'b1;
            g[2 * COLS + 0] = 1'b1;
            for (int i = 0; i < 3; i++) begin
                run_gen(g, life_ref(g), "R2 glider wrap", 0);
                g = life_ref(g);
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule